// File: doc/BRIEF.md
# Time-Slot Interchange Channel Switch

This block is the switching core between up to four PCM multiplexes on the system side and a subscriber-side multiplex. Incoming channel bytes are presented one per cycle with their line and slot number and are stored in a two-bank data memory. One bank collects the current frame while the other holds the previous, complete frame. A `frame_sync` pulse swaps the two banks. For each outgoing slot, a connection memory gives the stored byte to send, or a 4-bit or 2-bit field of that byte, or it marks the slot as unconnected. The connection memory is programmed through a simple write port.

Slot timing comes from the surrounding framers, so the block cannot stall. Each interface is a plain strobe with no ready signal and no back-pressure. A write or read is accepted in the cycle its strobe is high. The result of a read appears on the output registers in the next cycle. A run of consecutive output slots can be chained into one grouped n×64 kb/s connection. Because reads always come from the completed bank, every member of a group comes from the same input frame, and the group keeps its order with a constant one-frame delay.

Connection word layout (14 bits):

| Bits | Meaning |
|------|---------|
| [13] | valid |
| [12:11] | width: 00 = 64 kb/s, 01 = 32 kb/s, 10 = 16 kb/s, 11 = 64 kb/s |
| [10:9] | field position |
| [8] | chain |
| [7:0] | source address (low AW bits used) |

Top module: `tsi_switch`

## Requirements
- R1: While `rst_n` is low and right after reset, `out_data` is 8'hFF and `out_oe_n` is 1. Reset clears every connection word to invalid, clears the data memory to zero and selects bank 0 for writing.
- R2: A byte written in one frame can be read only after the next `frame_sync`. Writes made during a frame never change the data read during that same frame.
- R3: The write address depends on `mode`. Mode 0 gives {line[1:0], slot[4:0]}. Mode 1 gives {line[0], slot[5:0]}. Modes 2 and 3 give slot[6:0] and ignore the line.
- R4: For a valid 64 kb/s word (width 00 or 11), the cycle after `out_req`, `out_data` equals the stored source byte and `out_oe_n` is 0.
- R5: For a valid 32 kb/s word (width 01), `out_data` is {4'hF, nibble}. Position bit 0 picks the nibble: 0 selects the low nibble, 1 selects the high nibble. `out_oe_n` is 0.
- R6: For a valid 16 kb/s word (width 10), `out_data` is {6'h3F, byte[2p+1:2p]}, where p is the field position. `out_oe_n` is 0.
- R7: For a word whose valid bit is 0, the cycle after `out_req`, `out_data` is 8'hFF and `out_oe_n` is 1.
- R8: When the chain bit is set, the source address is the source used by the previous `out_req` plus one, modulo SLOTS. Every `out_req` records its resolved source address.
- R9: In the cycle after a cycle without `out_req`, `out_data` is 8'hFF and `out_oe_n` is 1.
- R10: In a `frame_sync` cycle, the write already goes to the new bank. The read in that cycle already reads the frame that has just completed.
- R11: A connection write and a read of the same address in one cycle return the old word. The new word applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Port mode for the write address map |
| frame_sync | input | 1 | Frame boundary pulse; swaps the banks |
| wr_en | input | 1 | Incoming slot byte strobe |
| wr_line | input | 2 | Incoming line number |
| wr_slot | input | AW | Incoming slot number on that line |
| wr_data | input | 8 | Incoming slot byte |
| cm_we | input | 1 | Connection word write strobe |
| cm_addr | input | OAW | Output slot whose connection word is written |
| cm_wdata | input | 14 | Connection word |
| out_req | input | 1 | Read strobe for an output slot |
| out_slot | input | OAW | Output slot being read |
| out_data | output | 8 | Switched slot data, valid one cycle after the request |
| out_oe_n | output | 1 | Tristate control for the output line, low when `out_data` is valid |

## Verification
A `frame_sync` can arrive in the same cycle as an incoming write and an outgoing read. In the same way, a connection write can hit the very output slot being read. The bench produces both collisions with random strobes over several thousand cycles in all three modes. Sync pulses come at a fixed period and also at random short intervals. A behavioural model, which resolves each collision as R10 and R11 define it, is compared against the outputs on every cycle.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic [1:0] {
    WID_64  = 2'b00,
    WID_32  = 2'b01,
    WID_16  = 2'b10,
    WID_64B = 2'b11
  } width_e;

  typedef struct packed {
    logic       valid;
    width_e     width;
    logic [1:0] pos;
    logic       chain;
    logic [7:0] src;
  } conn_t;

  localparam int CONN_W = $bits(conn_t);
endpackage

// File: rtl/tsi_addr_map.sv
module tsi_addr_map #(
  parameter int AW = 7
) (
  input  logic [1:0]    mode,
  input  logic [1:0]    line,
  input  logic [AW-1:0] slot,
  output logic [AW-1:0] addr
);
  always_comb begin
    case (mode)
      2'd0:    addr = {line, slot[AW-3:0]};
      2'd1:    addr = {line[0], slot[AW-2:0]};
      default: addr = slot;
    endcase
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else if (we && (wbank == b[0])) begin
        mem[waddr] <= wdata;
      end
    end
    assign bank_rd[b] = mem[raddr];
  end

  assign rdata = rbank ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  conn_t         wdata,
  input  logic [AW-1:0] raddr,
  output conn_t         rdata
);
  conn_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tsi_field_sel.sv
module tsi_field_sel
  import tsi_pkg::*;
(
  input  logic [7:0] din,
  input  width_e     width,
  input  logic [1:0] pos,
  output logic [7:0] dout
);
  always_comb begin
    case (width)
      WID_32:  dout = {4'hF, pos[0] ? din[7:4] : din[3:0]};
      WID_16:  dout = {6'h3F, din[2*pos +: 2]};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter  int SLOTS     = 128,
  parameter  int OUT_SLOTS = 128,
  localparam int AW        = $clog2(SLOTS),
  localparam int OAW       = $clog2(OUT_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic               frame_sync,
  input  logic               wr_en,
  input  logic [1:0]         wr_line,
  input  logic [AW-1:0]      wr_slot,
  input  logic [7:0]         wr_data,
  input  logic               cm_we,
  input  logic [OAW-1:0]     cm_addr,
  input  logic [CONN_W-1:0]  cm_wdata,
  input  logic               out_req,
  input  logic [OAW-1:0]     out_slot,
  output logic [7:0]         out_data,
  output logic               out_oe_n
);
  logic          wbank;
  logic          wbank_eff;
  logic [AW-1:0] waddr;
  logic [AW-1:0] src_addr;
  logic [AW-1:0] last_src;
  logic [7:0]    rd_byte;
  logic [7:0]    sel_byte;
  conn_t         cword;

  assign wbank_eff = frame_sync ? ~wbank : wbank;

  tsi_addr_map #(.AW(AW)) i_map (
    .mode(mode), .line(wr_line), .slot(wr_slot), .addr(waddr)
  );

  tsi_conn_mem #(.DEPTH(OUT_SLOTS), .AW(OAW)) i_cm (
    .clk(clk), .rst_n(rst_n), .we(cm_we), .waddr(cm_addr),
    .wdata(conn_t'(cm_wdata)), .raddr(out_slot), .rdata(cword)
  );

  assign src_addr = cword.chain ? AW'(last_src + 1'b1) : cword.src[AW-1:0];

  tsi_data_mem #(.DEPTH(SLOTS), .AW(AW)) i_dm (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .wbank(wbank_eff),
    .waddr(waddr), .wdata(wr_data), .rbank(~wbank_eff),
    .raddr(src_addr), .rdata(rd_byte)
  );

  tsi_field_sel i_sel (
    .din(rd_byte), .width(cword.width), .pos(cword.pos), .dout(sel_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbank    <= 1'b0;
      last_src <= '0;
      out_data <= 8'hFF;
      out_oe_n <= 1'b1;
    end else begin
      wbank <= wbank_eff;
      if (out_req) last_src <= src_addr;
      if (out_req && cword.valid) begin
        out_data <= sel_byte;
        out_oe_n <= 1'b0;
      end else begin
        out_data <= 8'hFF;
        out_oe_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_sync,
  input logic       out_req,
  input logic [7:0] out_data,
  input logic       out_oe_n,
  input logic       wbank
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !out_req |=> (out_oe_n && out_data == 8'hFF)); // R9
  AST_TRISTATE_IDLE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_oe_n |-> out_data == 8'hFF); // R7
  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> wbank != $past(wbank)); // R10
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(wbank)); // R2
endmodule

bind tsi_switch tsi_switch_chk i_tsi_switch_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .out_req(out_req),
  .out_data(out_data), .out_oe_n(out_oe_n), .wbank(wbank)
);

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic frame_sync = 1'b0, wr_en = 1'b0, cm_we = 1'b0, out_req = 1'b0;
  logic [1:0] wr_line = '0;
  logic [AW-1:0] wr_slot = '0, cm_addr = '0, out_slot = '0;
  logic [7:0] wr_data = '0;
  logic [13:0] cm_wdata = '0;
  logic [7:0] out_data;
  logic out_oe_n;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  tsi_switch i_tsi_switch (.*);

  // behavioural reference
  byte unsigned dm [2][128];
  logic [13:0] cm [128];
  bit ref_wbank;
  int ref_last;
  logic [7:0] exp_data = 8'hFF;
  logic exp_oe_n = 1'b1;
  string exp_tag = "R1";

  function automatic int map_addr(int md, int ln, int sl);
    if (md == 0) return ln * 32 + (sl % 32);
    if (md == 1) return (ln % 2) * 64 + (sl % 64);
    return sl;
  endfunction

  task automatic ref_reset();
    for (int b = 0; b < 2; b++) for (int i = 0; i < 128; i++) dm[b][i] = 0;
    for (int i = 0; i < 128; i++) cm[i] = '0;
    ref_wbank = 0; ref_last = 0; exp_data = 8'hFF; exp_oe_n = 1'b1; exp_tag = "R1";
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit wb, rb;
      logic [13:0] w;
      int src, p;
      byte unsigned b;
      wb = frame_sync ? !ref_wbank : ref_wbank;
      rb = !wb;
      if (out_req) begin
        w = cm[out_slot];
        src = w[8] ? (ref_last + 1) % 128 : w[6:0];
        ref_last = src;
        p = w[10:9];
        b = dm[rb][src];
        if (!w[13]) begin
          exp_data = 8'hFF; exp_oe_n = 1; exp_tag = "R7";
        end else begin
          exp_oe_n = 0;
          if (w[12:11] == 2'b01) begin
            exp_data = {4'hF, w[9] ? b[7:4] : b[3:0]}; exp_tag = "R5";
          end else if (w[12:11] == 2'b10) begin
            exp_data = {6'h3F, 2'((b >> (2 * p)) & 3)}; exp_tag = "R6";
          end else begin
            exp_data = b; exp_tag = "R4";
          end
          if (w[8]) exp_tag = {exp_tag, " R8"};
          exp_tag = {exp_tag, " R2 R3"};
        end
        if (frame_sync) exp_tag = {exp_tag, " R10"};
        if (cm_we && cm_addr == out_slot) exp_tag = {exp_tag, " R11"};
      end else begin
        exp_data = 8'hFF; exp_oe_n = 1; exp_tag = "R9";
      end
      if (wr_en) dm[wb][map_addr(mode, wr_line, wr_slot)] = wr_data;
      if (cm_we) cm[cm_addr] = cm_wdata;
      ref_wbank = wb;
    end
  end

  task automatic check(string tag, logic [7:0] d, logic oe);
    n_cmp++;
    if (out_data !== d || out_oe_n !== oe) begin
      n_bad++;
      $display("FAIL %s: data=%h oe_n=%b expected data=%h oe_n=%b", tag, out_data, out_oe_n, d, oe);
    end
  endtask

  // compare on every clock, sampled at the falling edge
  bit cmp_on = 0;
  always @(negedge clk) begin
    cyc++;
    if (cmp_on) check(exp_tag, exp_data, exp_oe_n);
  end

  task automatic idle();
    frame_sync = 0; wr_en = 0; cm_we = 0; out_req = 0;
  endtask

  initial begin
    ref_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'hFF, 1'b1);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 8'hFF, 1'b1);
    cmp_on = 1;
    // directed: mode 2, slot 5 gets A5, connection out 3 -> src 5 at 64k
    mode = 2;
    cm_we = 1; cm_addr = 3; cm_wdata = {1'b1, 2'b00, 2'b00, 1'b0, 8'd5};
    @(negedge clk); idle();
    wr_en = 1; wr_slot = 5; wr_data = 8'hA5;
    @(negedge clk); idle();
    out_req = 1; out_slot = 3;            // same frame: old data (R2)
    @(negedge clk); idle();
    check("R2 same-frame read", 8'h00, 1'b0);
    frame_sync = 1; out_req = 1; out_slot = 3; // sync cycle reads completed frame (R10)
    @(negedge clk); idle();
    check("R10 read at sync", 8'hA5, 1'b0);
    // random phase
    for (int k = 0; k < 9000; k++) begin
      if (k % 3000 == 0) mode = 2'(k / 3000);
      frame_sync = ((k % 128) == 127) || ($urandom_range(0, 199) == 0);
      wr_en = $urandom_range(0, 9) < 7;
      wr_line = 2'($urandom); wr_slot = AW'($urandom); wr_data = 8'($urandom);
      out_req = $urandom_range(0, 9) < 9;
      out_slot = $urandom_range(0, 3) == 0 ? AW'($urandom) : AW'(k);
      cm_we = $urandom_range(0, 9) == 0;
      cm_addr = ($urandom_range(0, 3) == 0) ? out_slot : AW'($urandom);
      cm_wdata = {($urandom_range(0, 3) != 0), 2'($urandom), 2'($urandom),
                  ($urandom_range(0, 4) == 0), 8'($urandom)};
      @(negedge clk);
    end
    idle();
    repeat (3) @(negedge clk);
    cmp_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule